// File: doc/BRIEF.md
# Age-Ordered Multi-Class Issue Selector

This block sits between the ready-detection logic and the execution units of an out-of-order core. Every instruction whose operands are ready is pushed into a small per-class queue by sequence number, and each cycle the block grants up to `ISSUE_W` instructions. The oldest instruction is always served first, where a smaller sequence number means an older instruction. Each class queue is kept sorted, so its head is always the oldest ready instruction of that class. The heads of the non-empty classes form the age ordering that the selector walks.

Each class has a count of free functional units. A class with no free unit drops out of the walk for that cycle, and younger instructions of other classes still issue. Class 0 stands for instructions that need no functional unit, and these issue whatever the unit counts say. A head that the caller marks as squashed leaves its queue without being granted and uses no issue lane. A push to a full class queue is refused through `push_ready`.

Grants are combinational from the registered queue contents and the current unit counts and squash flags. Queue updates (pops, then the sorted insertion of the push) take effect at the clock edge.

Top module: `age_issue_selector`

## Requirements
- R1: No more than ISSUE_W grants are made in a cycle. Lanes fill from lane 0 upward with no gap: a valid lane k+1 implies a valid lane k.
- R2: Grants are oldest-first across classes. Lane 0 carries the eligible instruction with the smallest sequence number (unsigned compare, no wraparound). Each later lane carries the next smallest, so lane sequence numbers do not decrease. Ties go to the lower class index.
- R3: Each class queue is held in ascending sequence order. A push older than the current head becomes the new head and is granted before the previous head.
- R4: Once a head is granted, the next entry of that class becomes eligible in the same cycle. One class may therefore fill several lanes, limited by its free-unit count.
- R5: A class whose free-unit count (field `fu_free[c*FU_W +: FU_W]`) is zero is skipped. Younger instructions of other classes still issue. No class c other than 0 gets more grants in a cycle than its count.
- R6: Class 0 needs no functional unit. Its instructions are granted whatever its `fu_free` field holds.
- R7: When `head_squash[c]` is set and class c is non-empty, that head is removed at the clock edge without a grant and without using a lane. Class c offers nothing else in that cycle.
- R8: `push_ready` is low when the queue selected by `push_class` holds QDEPTH entries. A push in that cycle is dropped and never granted.
- R9: An accepted push enters its queue at the clock edge. It can be granted from the following cycle onward, never in the cycle of the push.
- R10: Synchronous reset empties every queue: no grant is valid and `push_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | A ready instruction is offered this cycle |
| push_class | input | CLS_BITS | Operation class of the offered instruction (0 = no unit needed) |
| push_seq | input | SEQ_BITS | Sequence number of the offered instruction |
| push_ready | output | 1 | The selected class queue has room |
| fu_free | input | NUM_CLASSES*FU_W | Free functional units per class, FU_W bits each |
| head_squash | input | NUM_CLASSES | Discard the head of each marked class |
| grant_valid | output | ISSUE_W | Lane holds a grant |
| grant_class | output | ISSUE_W*CLS_BITS | Class of each lane's grant |
| grant_seq | output | ISSUE_W*SEQ_BITS | Sequence number of each lane's grant |

## Verification
The main walk is exercised in four ways. Heads are interleaved across classes, which tells age order apart from class-index order. A push older than its queue's head tells sorted insertion apart from FIFO order. One class is filled with several entries while its units are plentiful, which shows whether a class can fill more than one lane. Three classes are made ready with only two lanes free, which tests the lane limit and leaves one instruction behind for the next cycle. Further patterns set one class's unit count to zero while an older instruction waits there, squash a head that has a successor behind it, and issue class 0 with every unit count at zero. These separate the skip, discard and no-unit paths from ordinary age selection.

// File: rtl/issue_sel_pkg.sv
package issue_sel_pkg;

    parameter int unsigned SEQ_BITS = 8;
    parameter int unsigned CLS_BITS = 2;
    parameter int unsigned NUM_CLS  = 4;

    typedef logic [SEQ_BITS-1:0] seq_t;
    typedef logic [CLS_BITS-1:0] cls_t;

    // Smaller sequence number is older; no wraparound handling.
    function automatic logic is_older(input seq_t a, input seq_t b);
        return a < b;
    endfunction

endpackage

// File: rtl/sel_class_queue.sv
module sel_class_queue
    import issue_sel_pkg::*;
#(
    parameter int QDEPTH = 4,
    parameter int CNT_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    push_en,
    input  seq_t                    push_seq,
    input  logic [CNT_W-1:0]        pop_cnt,
    output seq_t [QDEPTH-1:0]       ent_o,
    output logic [CNT_W-1:0]        cnt_o
);

    seq_t [QDEPTH-1:0] ent_q, ent_d, shifted;
    logic [CNT_W-1:0]  cnt_q, cnt_d, remain;
    int                ins_pos;

    always_comb begin
        remain = cnt_q - pop_cnt;
        // drop the popped front entries
        for (int i = 0; i < QDEPTH; i++) begin
            shifted[i] = '0;
            for (int k = 0; k < QDEPTH; k++) begin
                if (k == i + int'(pop_cnt)) shifted[i] = ent_q[k];
            end
        end
        // sorted insertion point: after every surviving entry not younger
        ins_pos = 0;
        for (int i = 0; i < QDEPTH; i++) begin
            if (i < int'(remain) && !is_older(push_seq, shifted[i])) ins_pos++;
        end
        ent_d = shifted;
        if (push_en) begin
            for (int i = 1; i < QDEPTH; i++) begin
                if (i > ins_pos) ent_d[i] = shifted[i-1];
            end
            for (int i = 0; i < QDEPTH; i++) begin
                if (i == ins_pos) ent_d[i] = push_seq;
            end
        end
        cnt_d = remain + CNT_W'(push_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ent_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            ent_q <= ent_d;
        end
    end

    assign ent_o = ent_q;
    assign cnt_o = cnt_q;

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) <= QDEPTH);

    generate
        for (genvar g = 0; g + 1 < QDEPTH; g++) begin : g_sort
            // R3
            sorted_order_chk: assert property (@(posedge clk) disable iff (rst)
                (g + 1 < int'(cnt_q)) |-> (ent_q[g] <= ent_q[g+1]));
        end
    endgenerate

endmodule

// File: rtl/sel_oldest_pick.sv
module sel_oldest_pick
    import issue_sel_pkg::*;
#(
    parameter int NUM_CLASSES = 4,
    parameter int QDEPTH      = 4,
    parameter int ISSUE_W     = 2,
    parameter int FU_W        = 2,
    parameter int CNT_W       = 3
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  seq_t [NUM_CLASSES-1:0][QDEPTH-1:0]   ent_i,
    input  logic [NUM_CLASSES-1:0][CNT_W-1:0]    cnt_i,
    input  logic [NUM_CLASSES*FU_W-1:0]          fu_i,
    input  logic [NUM_CLASSES-1:0]               squash_i,
    output logic [ISSUE_W-1:0]                   lane_vld,
    output cls_t [ISSUE_W-1:0]                   lane_cls,
    output seq_t [ISSUE_W-1:0]                   lane_seq,
    output logic [NUM_CLASSES-1:0][CNT_W-1:0]    pop_o
);

    int   taken [NUM_CLASSES];
    logic open_c [NUM_CLASSES];

    always_comb begin
        int   lim;
        int   best_c;
        logic found;
        logic ok;
        seq_t best_s;
        seq_t cand;
        for (int c = 0; c < NUM_CLASSES; c++) begin
            taken[c]  = 0;
            open_c[c] = (cnt_i[c] != '0) && !squash_i[c];
        end
        for (int l = 0; l < ISSUE_W; l++) begin
            found  = 1'b0;
            best_c = 0;
            best_s = '0;
            for (int c = 0; c < NUM_CLASSES; c++) begin
                lim  = (c == 0) ? QDEPTH : int'(fu_i[c*FU_W +: FU_W]);
                ok   = open_c[c] && (taken[c] < int'(cnt_i[c])) && (taken[c] < lim);
                cand = '0;
                for (int k = 0; k < QDEPTH; k++) begin
                    if (k == taken[c]) cand = ent_i[c][k];
                end
                if (ok && (!found || is_older(cand, best_s))) begin
                    found  = 1'b1;
                    best_c = c;
                    best_s = cand;
                end
            end
            lane_vld[l] = found;
            lane_cls[l] = CLS_BITS'(best_c);
            lane_seq[l] = best_s;
            if (found) taken[best_c] = taken[best_c] + 1;
        end
        for (int c = 0; c < NUM_CLASSES; c++) begin
            pop_o[c] = CNT_W'(taken[c]) + CNT_W'((cnt_i[c] != '0) && squash_i[c]);
        end
    end

    generate
        for (genvar g = 1; g < ISSUE_W; g++) begin : g_lane
            // R1
            lane_packed_chk: assert property (@(posedge clk) disable iff (rst)
                lane_vld[g] |-> lane_vld[g-1]);
            // R2
            lane_age_order_chk: assert property (@(posedge clk) disable iff (rst)
                lane_vld[g] |-> (lane_seq[g-1] <= lane_seq[g]));
        end
    endgenerate

endmodule

// File: rtl/age_issue_selector.sv
module age_issue_selector
    import issue_sel_pkg::*;
#(
    parameter int NUM_CLASSES = NUM_CLS,
    parameter int QDEPTH      = 4,
    parameter int ISSUE_W     = 2,
    parameter int FU_W        = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           push_valid,
    input  logic [CLS_BITS-1:0]            push_class,
    input  logic [SEQ_BITS-1:0]            push_seq,
    output logic                           push_ready,
    input  logic [NUM_CLASSES*FU_W-1:0]    fu_free,
    input  logic [NUM_CLASSES-1:0]         head_squash,
    output logic [ISSUE_W-1:0]             grant_valid,
    output logic [ISSUE_W*CLS_BITS-1:0]    grant_class,
    output logic [ISSUE_W*SEQ_BITS-1:0]    grant_seq
);

    localparam int CNT_W = $clog2(QDEPTH + 1);

    seq_t [NUM_CLASSES-1:0][QDEPTH-1:0] q_ent;
    logic [NUM_CLASSES-1:0][CNT_W-1:0]  q_cnt;
    logic [NUM_CLASSES-1:0][CNT_W-1:0]  q_pop;
    logic [NUM_CLASSES-1:0]             q_push;
    logic [ISSUE_W-1:0]                 l_vld;
    cls_t [ISSUE_W-1:0]                 l_cls;
    seq_t [ISSUE_W-1:0]                 l_seq;

    always_comb begin
        push_ready = 1'b0;
        for (int c = 0; c < NUM_CLASSES; c++) begin
            if (push_class == CLS_BITS'(c)) push_ready = (int'(q_cnt[c]) < QDEPTH);
        end
    end

    generate
        for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_cls
            assign q_push[g] = push_valid && push_ready && (push_class == CLS_BITS'(g));

            sel_class_queue #(
                .QDEPTH (QDEPTH),
                .CNT_W  (CNT_W)
            ) u_queue (
                .clk      (clk),
                .rst      (rst),
                .push_en  (q_push[g]),
                .push_seq (push_seq),
                .pop_cnt  (q_pop[g]),
                .ent_o    (q_ent[g]),
                .cnt_o    (q_cnt[g])
            );
        end
    endgenerate

    sel_oldest_pick #(
        .NUM_CLASSES (NUM_CLASSES),
        .QDEPTH      (QDEPTH),
        .ISSUE_W     (ISSUE_W),
        .FU_W        (FU_W),
        .CNT_W       (CNT_W)
    ) u_pick (
        .clk      (clk),
        .rst      (rst),
        .ent_i    (q_ent),
        .cnt_i    (q_cnt),
        .fu_i     (fu_free),
        .squash_i (head_squash),
        .lane_vld (l_vld),
        .lane_cls (l_cls),
        .lane_seq (l_seq),
        .pop_o    (q_pop)
    );

    assign grant_valid = l_vld;
    assign grant_class = l_cls;
    assign grant_seq   = l_seq;

    // per-class view of the lanes, for checking only
    logic [NUM_CLASSES-1:0] cls_hit;
    always_comb begin
        cls_hit = '0;
        for (int l = 0; l < ISSUE_W; l++) begin
            for (int c = 0; c < NUM_CLASSES; c++) begin
                if (l_vld[l] && l_cls[l] == CLS_BITS'(c)) cls_hit[c] = 1'b1;
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_chk
            // R7
            squashed_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
                (head_squash[g] && q_cnt[g] != '0) |-> !cls_hit[g]);
            if (g != 0) begin : g_fu
                // R5
                no_unit_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
                    (fu_free[g*FU_W +: FU_W] == '0) |-> !cls_hit[g]);
            end
        end
    endgenerate

    // R10
    reset_empty_chk: assert property (@(posedge clk) $past(rst) |-> (l_vld == '0));

endmodule

// File: tb/age_issue_selector_test.sv
module age_issue_selector_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        push_valid;
    logic [1:0]  push_class;
    logic [7:0]  push_seq;
    logic        push_ready;
    logic [7:0]  fu_free;
    logic [3:0]  head_squash;
    logic [1:0]  grant_valid;
    logic [3:0]  grant_class;
    logic [15:0] grant_seq;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    age_issue_selector uut (
        .clk(clk), .rst(rst),
        .push_valid(push_valid), .push_class(push_class), .push_seq(push_seq),
        .push_ready(push_ready), .fu_free(fu_free), .head_squash(head_squash),
        .grant_valid(grant_valid), .grant_class(grant_class), .grant_seq(grant_seq)
    );

    typedef struct packed {
        logic [3:0] req;
        logic       pv;
        logic [1:0] pc;
        logic [7:0] ps;
        logic [7:0] fu;   // {c3,c2,c1,c0}, 2 bits each
        logic [3:0] sq;
        logic       rdy;
        logic       v0;
        logic [1:0] c0;
        logic [7:0] s0;
        logic       v1;
        logic [1:0] c1;
        logic [7:0] s1;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VEC [NV] = '{
        '{4'd9, 1'b1, 2'd1, 8'd20, 8'h00, 4'h0, 1'b1, 1'b0, 2'd0, 8'd0,   1'b0, 2'd0, 8'd0},  // R9
        '{4'd5, 1'b1, 2'd2, 8'd10, 8'h00, 4'h0, 1'b1, 1'b0, 2'd0, 8'd0,   1'b0, 2'd0, 8'd0},  // R5
        '{4'd3, 1'b1, 2'd1, 8'd5,  8'h00, 4'h0, 1'b1, 1'b0, 2'd0, 8'd0,   1'b0, 2'd0, 8'd0},  // R3
        '{4'd2, 1'b0, 2'd0, 8'd0,  8'hFF, 4'h0, 1'b1, 1'b1, 2'd1, 8'd5,   1'b1, 2'd2, 8'd10}, // R2
        '{4'd3, 1'b1, 2'd3, 8'd30, 8'hFF, 4'h0, 1'b1, 1'b1, 2'd1, 8'd20,  1'b0, 2'd0, 8'd0},  // R3
        '{4'd5, 1'b1, 2'd3, 8'd25, 8'h3F, 4'h0, 1'b1, 1'b0, 2'd0, 8'd0,   1'b0, 2'd0, 8'd0},  // R5
        '{4'd5, 1'b1, 2'd1, 8'd40, 8'h7F, 4'h0, 1'b1, 1'b1, 2'd3, 8'd25,  1'b0, 2'd0, 8'd0},  // R5
        '{4'd5, 1'b0, 2'd0, 8'd0,  8'h3F, 4'h0, 1'b1, 1'b1, 2'd1, 8'd40,  1'b0, 2'd0, 8'd0},  // R5
        '{4'd2, 1'b1, 2'd0, 8'd50, 8'hFF, 4'h0, 1'b1, 1'b1, 2'd3, 8'd30,  1'b0, 2'd0, 8'd0},  // R2
        '{4'd6, 1'b1, 2'd0, 8'd45, 8'h00, 4'h0, 1'b1, 1'b1, 2'd0, 8'd50,  1'b0, 2'd0, 8'd0},  // R6
        '{4'd6, 1'b0, 2'd0, 8'd0,  8'h00, 4'h0, 1'b1, 1'b1, 2'd0, 8'd45,  1'b0, 2'd0, 8'd0},  // R6
        '{4'd7, 1'b1, 2'd2, 8'd60, 8'h00, 4'h0, 1'b1, 1'b0, 2'd0, 8'd0,   1'b0, 2'd0, 8'd0},  // R7
        '{4'd7, 1'b1, 2'd2, 8'd61, 8'h00, 4'h0, 1'b1, 1'b0, 2'd0, 8'd0,   1'b0, 2'd0, 8'd0},  // R7
        '{4'd7, 1'b1, 2'd1, 8'd70, 8'h00, 4'h0, 1'b1, 1'b0, 2'd0, 8'd0,   1'b0, 2'd0, 8'd0},  // R7
        '{4'd7, 1'b0, 2'd0, 8'd0,  8'hFF, 4'h4, 1'b1, 1'b1, 2'd1, 8'd70,  1'b0, 2'd0, 8'd0},  // R7
        '{4'd7, 1'b0, 2'd0, 8'd0,  8'hFF, 4'h0, 1'b1, 1'b1, 2'd2, 8'd61,  1'b0, 2'd0, 8'd0},  // R7
        '{4'd3, 1'b1, 2'd1, 8'd4,  8'h00, 4'h0, 1'b1, 1'b0, 2'd0, 8'd0,   1'b0, 2'd0, 8'd0},  // R3
        '{4'd3, 1'b1, 2'd1, 8'd3,  8'h00, 4'h0, 1'b1, 1'b0, 2'd0, 8'd0,   1'b0, 2'd0, 8'd0},  // R3
        '{4'd3, 1'b1, 2'd1, 8'd2,  8'h00, 4'h0, 1'b1, 1'b0, 2'd0, 8'd0,   1'b0, 2'd0, 8'd0},  // R3
        '{4'd8, 1'b1, 2'd1, 8'd1,  8'h00, 4'h0, 1'b1, 1'b0, 2'd0, 8'd0,   1'b0, 2'd0, 8'd0},  // R8
        '{4'd8, 1'b1, 2'd1, 8'd9,  8'h00, 4'h0, 1'b0, 1'b0, 2'd0, 8'd0,   1'b0, 2'd0, 8'd0},  // R8
        '{4'd4, 1'b0, 2'd0, 8'd0,  8'hFF, 4'h0, 1'b1, 1'b1, 2'd1, 8'd1,   1'b1, 2'd1, 8'd2},  // R4
        '{4'd4, 1'b0, 2'd0, 8'd0,  8'hFF, 4'h0, 1'b1, 1'b1, 2'd1, 8'd3,   1'b1, 2'd1, 8'd4},  // R4
        '{4'd8, 1'b0, 2'd0, 8'd0,  8'hFF, 4'h0, 1'b1, 1'b0, 2'd0, 8'd0,   1'b0, 2'd0, 8'd0},  // R8
        '{4'd1, 1'b1, 2'd1, 8'd100,8'h00, 4'h0, 1'b1, 1'b0, 2'd0, 8'd0,   1'b0, 2'd0, 8'd0},  // R1
        '{4'd1, 1'b1, 2'd2, 8'd90, 8'h00, 4'h0, 1'b1, 1'b0, 2'd0, 8'd0,   1'b0, 2'd0, 8'd0},  // R1
        '{4'd1, 1'b1, 2'd3, 8'd95, 8'h00, 4'h0, 1'b1, 1'b0, 2'd0, 8'd0,   1'b0, 2'd0, 8'd0},  // R1
        '{4'd1, 1'b0, 2'd0, 8'd0,  8'hFF, 4'h0, 1'b1, 1'b1, 2'd2, 8'd90,  1'b1, 2'd3, 8'd95}, // R1
        '{4'd1, 1'b0, 2'd0, 8'd0,  8'hFF, 4'h0, 1'b1, 1'b1, 2'd1, 8'd100, 1'b0, 2'd0, 8'd0}   // R1
    };

    task automatic check_lane(input int idx, input int req, input int lane,
                              input logic ev, input logic [1:0] ec, input logic [7:0] es);
        logic       av;
        logic [1:0] ac;
        logic [7:0] as;
        av = grant_valid[lane];
        ac = grant_class[lane*2 +: 2];
        as = grant_seq[lane*8 +: 8];
        n_cmp++;
        if (av !== ev || (ev && (ac !== ec || as !== es))) begin
            n_bad++;
            $display("FAIL step %0d R%0d lane %0d: actual v=%0b c=%0d s=%0d expected v=%0b c=%0d s=%0d",
                     idx, req, lane, av, ac, as, ev, ec, es);
        end
    endtask

    task automatic check_rdy(input int idx, input int req, input logic er);
        n_cmp++;
        if (push_ready !== er) begin
            n_bad++;
            $display("FAIL step %0d R%0d push_ready: actual %0b expected %0b",
                     idx, req, push_ready, er);
        end
    endtask

    task automatic drive(input logic pv, input logic [1:0] pc, input logic [7:0] ps,
                         input logic [7:0] fu, input logic [3:0] sq);
        @(negedge clk);
        push_valid  = pv;
        push_class  = pc;
        push_seq    = ps;
        fu_free     = fu;
        head_squash = sq;
        #5;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog R0: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        push_valid = 1'b0; push_class = '0; push_seq = '0;
        fu_free = 8'hFF; head_squash = '0;
        repeat (3) @(posedge clk);
        // R10: reset state
        drive(1'b0, 2'd0, 8'd0, 8'hFF, 4'h0);
        rst = 1'b0;
        check_rdy(-1, 10, 1'b1);
        check_lane(-1, 10, 0, 1'b0, 2'd0, 8'd0);
        check_lane(-1, 10, 1, 1'b0, 2'd0, 8'd0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].pv, VEC[i].pc, VEC[i].ps, VEC[i].fu, VEC[i].sq);
            check_rdy(i, int'(VEC[i].req), VEC[i].rdy);
            check_lane(i, int'(VEC[i].req), 0, VEC[i].v0, VEC[i].c0, VEC[i].s0);
            check_lane(i, int'(VEC[i].req), 1, VEC[i].v1, VEC[i].c1, VEC[i].s1);
        end

        // R9: push with all units free is not granted in its own cycle
        drive(1'b1, 2'd2, 8'd33, 8'hFF, 4'h0);
        check_lane(100, 9, 0, 1'b0, 2'd0, 8'd0);
        drive(1'b0, 2'd0, 8'd0, 8'hFF, 4'h0);
        check_lane(101, 9, 0, 1'b1, 2'd2, 8'd33);

        // R10: mid-run reset discards queued entries
        drive(1'b1, 2'd1, 8'd7, 8'h00, 4'h0);
        drive(1'b1, 2'd3, 8'd8, 8'h00, 4'h0);
        rst = 1'b1;
        drive(1'b0, 2'd0, 8'd0, 8'hFF, 4'h0);
        rst = 1'b0;
        drive(1'b0, 2'd0, 8'd0, 8'hFF, 4'h0);
        check_lane(102, 10, 0, 1'b0, 2'd0, 8'd0);
        check_lane(102, 10, 1, 1'b0, 2'd0, 8'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule